// File: doc/BRIEF.md
# Storage port initialization handshake

This block is the register front end of a mass-storage controller port on a host bus. It exposes two slave registers, selected by one address bit. The first is an initialization/poll register. The second is a status/address register that the host writes with setup words and reads for handshake status. Together they carry a four-step bring-up dialogue between host and controller.

The first word the host writes into the status/address register is the configuration word. It is decoded into an interrupt vector, an interrupt enable and the sizes of the command and response rings. At each later step the block publishes a status value back through the same register. Some of these values echo fields of the configuration word, and the last one carries a controller identification byte. Whenever a step sets a new status value and interrupts are allowed, the block raises an interrupt request that carries the decoded vector. The new status value becomes readable on the same clock edge that raises the request, so the host never sees the request ahead of the status it announces. Any access to the initialization register restarts the dialogue from the beginning.

The command and response ring processing and the data movement belong to the controller behind this block. From that side, only a pulse saying that the communication area is ready enters the block.

Top module: `stport_init`

## Requirements
- R1: After reset, `sa_rdata` is 0, `init_phase` is 0 (idle), `irq_req` is 0, `cfg_int_en` is 0, both ring lengths are 1, and `cfg_vector` holds the default vector, octal 154 (0x06C).
- R2: A read or a write with `reg_sel` = 0 (initialization register) sets `sa_rdata` to 0 and `init_phase` to 0 and drops any pending `irq_req`, all visible after the next clock edge. The configuration outputs keep their values.
- R3: A write with `reg_sel` = 1 in phase 0 takes the written word as the configuration word. `cfg_vector` becomes word[6:0] shifted left by two. `cfg_int_en` becomes word[7]. `cfg_rsp_len` becomes 1 shifted left by word[10:8]. `cfg_cmd_len` becomes 1 shifted left by word[13:11]. `irq_vector` equals `cfg_vector` from the same edge.
- R4: That configuration write moves `init_phase` to 2, and `sa_rdata` reads 0x1000 OR the word's bits 15:8.
- R5: A status/address write in phase 2 moves `init_phase` to 3, and `sa_rdata` reads 0x2000 OR bits 7:0 of the configuration word.
- R6: A status/address write in phase 3 moves `init_phase` to 4, and `sa_rdata` reads the identification byte `CTRL_ID` (default 0x2B) in its low byte with a zero high byte.
- R7: At each of the three status updates, `irq_req` rises on the same edge as `sa_rdata` changes, and only if the vector is nonzero and the interrupt enable is set (or the dialogue is complete). Otherwise `sa_rdata` is still updated and `irq_req` stays low.
- R8: A raised `irq_req` stays high until `irq_ack` is sampled high, then falls after that edge. If a new request arises in the acknowledging cycle, `irq_req` stays high.
- R9: In phase 4, a `comm_ready` pulse moves `init_phase` to 5 (complete) and leaves `sa_rdata` unchanged. A `comm_ready` pulse in any other phase is ignored.
- R10: In phases 4 and 5, status/address writes change neither `sa_rdata` nor `init_phase` and raise no request. Status/address reads have no effect in any phase.
- R11: `irq_level` drives the constant priority level `IRQ_LEVEL` (default 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_sel | input | 1 | 0 selects the initialization register, 1 the status/address register |
| reg_wdata | input | 16 | Write data |
| comm_ready | input | 1 | Pulse from the controller: communication area is set up |
| irq_ack | input | 1 | Interrupt grant from the bus |
| sa_rdata | output | 16 | Current status/address read value |
| init_phase | output | 3 | Handshake phase: 0 idle, 2, 3, 4, 5 complete |
| cfg_vector | output | 9 | Decoded interrupt vector |
| cfg_int_en | output | 1 | Decoded interrupt enable |
| cfg_rsp_len | output | 8 | Response ring length in entries |
| cfg_cmd_len | output | 8 | Command ring length in entries |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 9 | Vector presented with the request |
| irq_level | output | 3 | Interrupt priority level |

## Verification
The handshake runs three times with different configuration words. The first word has the enable set and a nonzero vector, so requests are expected. The second has the enable clear, which shows that the status still updates with no request. The third has the enable set but a zero vector, which separates the enable term from the vector term of the request condition. The configuration words use distinct byte values, so a swapped echo of the high and low bytes, or a wrongly aligned length field, reads back wrong. Further patterns cover an acknowledge in the same cycle as a new request, an initialization-register access while a request is pending, a `comm_ready` pulse outside phase 4, and writes after completion.

// File: rtl/stport_pkg.sv
package stport_pkg;
   localparam int unsigned WORD_W      = 16;
   localparam int unsigned VEC_FIELD_W = 7;
   localparam int unsigned VEC_W       = VEC_FIELD_W + 2;
   localparam int unsigned LEN_EXP_W   = 3;
   localparam int unsigned LEN_W       = (1 << LEN_EXP_W);
   localparam int unsigned EN_BIT      = 7;
   localparam int unsigned RSP_LSB     = 8;
   localparam int unsigned CMD_LSB     = 11;
   localparam int unsigned BYTE_W      = 8;

   localparam logic [WORD_W-1:0] S2_MARK = 16'h1000;
   localparam logic [WORD_W-1:0] S3_MARK = 16'h2000;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_S2   = 3'd2,
      PH_S3   = 3'd3,
      PH_S4   = 3'd4,
      PH_DONE = 3'd5
   } phase_e;
endpackage

// File: rtl/stport_cfg.sv
module stport_cfg
   import stport_pkg::*;
#(
   parameter logic [VEC_W-1:0] DEF_VECTOR = 9'o154
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic [VEC_W-1:0]  vec_q,
   output logic              en_q,
   output logic [LEN_W-1:0]  rsp_len_q,
   output logic [LEN_W-1:0]  cmd_len_q,
   output logic [BYTE_W-1:0] lo_q,
   output logic [VEC_W-1:0]  vec_d,
   output logic              en_d
);
   localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

   logic [LEN_W-1:0] rsp_len_d, cmd_len_d;
   logic [VEC_W-1:0] vec_dec;

   assign vec_dec = {word[VEC_FIELD_W-1:0], 2'b00};

   always_comb begin
      vec_d     = vec_q;
      en_d      = en_q;
      rsp_len_d = rsp_len_q;
      cmd_len_d = cmd_len_q;
      if (load) begin
         vec_d     = vec_dec;
         en_d      = word[EN_BIT];
         rsp_len_d = LEN_ONE << word[RSP_LSB +: LEN_EXP_W];
         cmd_len_d = LEN_ONE << word[CMD_LSB +: LEN_EXP_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q     <= DEF_VECTOR;
         en_q      <= 1'b0;
         rsp_len_q <= LEN_ONE;
         cmd_len_q <= LEN_ONE;
         lo_q      <= '0;
      end else begin
         vec_q     <= vec_d;
         en_q      <= en_d;
         rsp_len_q <= rsp_len_d;
         cmd_len_q <= cmd_len_d;
         if (load) lo_q <= word[BYTE_W-1:0];
      end
   end

   AST_VEC_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (vec_q == {$past(word[VEC_FIELD_W-1:0]), 2'b00})) else $error("vector decode"); // R3
endmodule

// File: rtl/stport_fsm.sv
module stport_fsm
   import stport_pkg::*;
#(
   parameter logic [BYTE_W-1:0] CTRL_ID = 8'h2B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ip_hit,
   input  logic              sa_wr,
   input  logic              comm_ready,
   input  logic [BYTE_W-1:0] word_hi,
   input  logic [BYTE_W-1:0] cfg_lo,
   output phase_e            phase_q,
   output logic [WORD_W-1:0] sa_q,
   output logic              upd
);
   phase_e            phase_d;
   logic [WORD_W-1:0] sa_d;

   always_comb begin
      phase_d = phase_q;
      sa_d    = sa_q;
      upd     = 1'b0;
      if (ip_hit) begin
         phase_d = PH_IDLE;
         sa_d    = '0;
      end else begin
         if (sa_wr) begin
            unique case (phase_q)
               PH_IDLE: begin
                  phase_d = PH_S2;
                  sa_d    = S2_MARK | {{(WORD_W-BYTE_W){1'b0}}, word_hi};
                  upd     = 1'b1;
               end
               PH_S2: begin
                  phase_d = PH_S3;
                  sa_d    = S3_MARK | {{(WORD_W-BYTE_W){1'b0}}, cfg_lo};
                  upd     = 1'b1;
               end
               PH_S3: begin
                  phase_d = PH_S4;
                  sa_d    = {{(WORD_W-BYTE_W){1'b0}}, CTRL_ID};
                  upd     = 1'b1;
               end
               default: ;
            endcase
         end
         if (comm_ready && phase_q == PH_S4) phase_d = PH_DONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sa_q    <= '0;
      end else begin
         phase_q <= phase_d;
         sa_q    <= sa_d;
      end
   end

   AST_IP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ip_hit |=> (sa_q == '0 && phase_q == PH_IDLE)) else $error("hard init"); // R2
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE && !ip_hit) |=> (phase_q == PH_DONE)) else $error("done lost"); // R9
   AST_SA_FROZEN_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_S4 || phase_q == PH_DONE) && !ip_hit) |=> $stable(sa_q)) else $error("late SA change"); // R10
endmodule

// File: rtl/stport_irq.sv
module stport_irq
   import stport_pkg::*;
#(
   parameter bit IRQ_HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [VEC_W-1:0] vec_d,
   input  logic             en_d,
   input  logic             done,
   input  logic             ack,
   input  logic             ip_hit,
   output logic             req_q
);
   logic fire, req_d;

   assign fire = upd && (vec_d != '0) && (en_d || done);

   generate
      if (IRQ_HOLD) begin : g_hold
         always_comb begin
            if (ip_hit)    req_d = 1'b0;
            else if (fire) req_d = 1'b1;
            else if (ack)  req_d = 1'b0;
            else           req_d = req_q;
         end
         AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (req_q && !ack && !ip_hit) |=> req_q) else $error("request lost"); // R8
         AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_q && ack && !fire && !ip_hit) |=> !req_q) else $error("ack ignored"); // R8
      end else begin : g_pulse
         always_comb req_d = fire && !ip_hit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_d;
   end
endmodule

// File: rtl/stport_init.sv
module stport_init
   import stport_pkg::*;
#(
   parameter logic [VEC_W-1:0]  DEF_VECTOR = 9'o154,
   parameter logic [BYTE_W-1:0] CTRL_ID    = 8'h2B,
   parameter int unsigned       IRQ_LEVEL  = 5,
   parameter bit                IRQ_HOLD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic              reg_sel,
   input  logic [15:0]       reg_wdata,
   input  logic              comm_ready,
   input  logic              irq_ack,
   output logic [15:0]       sa_rdata,
   output logic [2:0]        init_phase,
   output logic [8:0]        cfg_vector,
   output logic              cfg_int_en,
   output logic [7:0]        cfg_rsp_len,
   output logic [7:0]        cfg_cmd_len,
   output logic              irq_req,
   output logic [8:0]        irq_vector,
   output logic [2:0]        irq_level
);
   localparam int unsigned LVL_W = 3;

   generate
      if (DEF_VECTOR[1:0] != 2'b00) begin : g_bad_vector
         $error("DEF_VECTOR must be a multiple of four");
      end
      if (IRQ_LEVEL >= (1 << LVL_W)) begin : g_bad_level
         $error("IRQ_LEVEL does not fit the level field");
      end
   endgenerate

   logic              ip_hit, sa_wr, load, upd, en_d;
   logic [VEC_W-1:0]  vec_d;
   logic [BYTE_W-1:0] cfg_lo;
   phase_e            phase;

   assign ip_hit = (reg_wr || reg_rd) && !reg_sel;
   assign sa_wr  = reg_wr && reg_sel;
   assign load   = sa_wr && (phase == PH_IDLE);

   stport_cfg #(.DEF_VECTOR(DEF_VECTOR)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .word      (reg_wdata),
      .vec_q     (cfg_vector),
      .en_q      (cfg_int_en),
      .rsp_len_q (cfg_rsp_len),
      .cmd_len_q (cfg_cmd_len),
      .lo_q      (cfg_lo),
      .vec_d     (vec_d),
      .en_d      (en_d)
   );

   stport_fsm #(.CTRL_ID(CTRL_ID)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ip_hit     (ip_hit),
      .sa_wr      (sa_wr),
      .comm_ready (comm_ready),
      .word_hi    (reg_wdata[WORD_W-1:BYTE_W]),
      .cfg_lo     (cfg_lo),
      .phase_q    (phase),
      .sa_q       (sa_rdata),
      .upd        (upd)
   );

   stport_irq #(.IRQ_HOLD(IRQ_HOLD)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (upd),
      .vec_d  (vec_d),
      .en_d   (en_d),
      .done   (phase == PH_DONE),
      .ack    (irq_ack),
      .ip_hit (ip_hit),
      .req_q  (irq_req)
   );

   assign init_phase = phase;
   assign irq_vector = cfg_vector;
   assign irq_level  = LVL_W'(IRQ_LEVEL);

   AST_IRQ_WITH_SA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> !$stable(sa_rdata)) else $error("request without SA update"); // R7
   AST_IRQ_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vector != '0)) else $error("request with zero vector"); // R7
endmodule

// File: tb/stport_init_test.sv
module stport_init_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 0, reg_rd = 0, reg_sel = 0, comm_ready = 0, irq_ack = 0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] sa_rdata;
   logic [2:0]  init_phase, irq_level;
   logic [8:0]  cfg_vector, irq_vector;
   logic        cfg_int_en, irq_req;
   logic [7:0]  cfg_rsp_len, cfg_cmd_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   stport_init uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .comm_ready(comm_ready), .irq_ack(irq_ack),
      .sa_rdata(sa_rdata), .init_phase(init_phase), .cfg_vector(cfg_vector),
      .cfg_int_en(cfg_int_en), .cfg_rsp_len(cfg_rsp_len), .cfg_cmd_len(cfg_cmd_len),
      .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level)
   );

   typedef struct {
      logic [15:0] sa;
      logic        irq;
      logic [2:0]  ph;
      logic [8:0]  vec;
      logic        en;
      logic [7:0]  rsp;
      logic [7:0]  cmd;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0, n_bad = 0;
   bit   finished = 0;

   // reference model state, from the requirements
   logic [15:0] m_sa = '0;
   logic        m_irq = 0;
   logic [2:0]  m_ph = 3'd0;
   logic [8:0]  m_vec = 9'h06C;
   logic        m_en = 0;
   logic [7:0]  m_rsp = 8'd1, m_cmd = 8'd1;
   logic [15:0] m_w1 = '0;

   task automatic op(input logic wr, input logic rd, input logic sel, input logic [15:0] d,
                     input logic ack, input logic cr, input string tag);
      logic ip, saw, fire;
      logic [2:0] ph_old;
      exp_t e;
      @(negedge clk);
      reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = d; irq_ack = ack; comm_ready = cr;
      @(posedge clk);
      #1;
      reg_wr = 0; reg_rd = 0; irq_ack = 0; comm_ready = 0;
      ip = (wr || rd) && !sel;
      saw = wr && sel;
      fire = 0;
      ph_old = m_ph;
      if (ip) begin
         m_ph = 3'd0; m_sa = '0; m_irq = 0;
      end else begin
         if (saw) begin
            case (ph_old)
               3'd0: begin
                  m_w1 = d; m_vec = {d[6:0], 2'b00}; m_en = d[7];
                  m_rsp = 8'd1 << d[10:8]; m_cmd = 8'd1 << d[13:11];
                  m_sa = 16'h1000 | {8'h00, d[15:8]}; m_ph = 3'd2; fire = 1;
               end
               3'd2: begin m_sa = 16'h2000 | {8'h00, m_w1[7:0]}; m_ph = 3'd3; fire = 1; end
               3'd3: begin m_sa = 16'h002B; m_ph = 3'd4; fire = 1; end
               default: ;
            endcase
         end
         if (cr && ph_old == 3'd4) m_ph = 3'd5;
         if (fire && m_vec != 0 && (m_en || ph_old == 3'd5)) m_irq = 1;
         else if (ack) m_irq = 0;
      end
      e.sa = m_sa; e.irq = m_irq; e.ph = m_ph; e.vec = m_vec; e.en = m_en;
      e.rsp = m_rsp; e.cmd = m_cmd; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: pops one expected item per cycle and compares
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (sa_rdata !== e.sa || irq_req !== e.irq || init_phase !== e.ph ||
             cfg_vector !== e.vec || irq_vector !== e.vec || cfg_int_en !== e.en ||
             cfg_rsp_len !== e.rsp || cfg_cmd_len !== e.cmd) begin
            n_bad++;
            $display("FAIL %s: got sa=%h irq=%b ph=%0d vec=%h ivec=%h en=%b rsp=%0d cmd=%0d, expected sa=%h irq=%b ph=%0d vec=%h en=%b rsp=%0d cmd=%0d",
                     e.tag, sa_rdata, irq_req, init_phase, cfg_vector, irq_vector, cfg_int_en,
                     cfg_rsp_len, cfg_cmd_len, e.sa, e.irq, e.ph, e.vec, e.en, e.rsp, e.cmd);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      op(0, 0, 0, 16'h0, 0, 0, "R1 reset state");
      @(negedge clk);
      n_cmp++;
      if (irq_level !== 3'd5) begin
         n_bad++;
         $display("FAIL R11: got level %0d, expected 5", irq_level);
      end
      // pass 1: enable set, nonzero vector
      op(1, 0, 1, 16'hA5C3, 0, 0, "R3 R4 R7 step-one decode with request");
      op(0, 0, 0, 16'h0, 0, 0, "R8 request held");
      op(0, 1, 1, 16'h0, 0, 0, "R10 SA read no effect");
      op(0, 0, 0, 16'h0, 1, 0, "R8 ack drops request");
      op(0, 0, 0, 16'h0, 0, 1, "R9 comm_ready ignored in phase 2");
      op(1, 0, 1, 16'h5555, 0, 0, "R5 step three echo low byte");
      op(1, 0, 1, 16'h1234, 1, 0, "R6 R8 step four id with ack same cycle");
      op(0, 0, 0, 16'h0, 1, 0, "R8 ack clears");
      op(1, 0, 1, 16'hFFFF, 0, 0, "R10 write in phase 4 ignored");
      op(0, 0, 0, 16'h0, 0, 1, "R9 comm_ready completes");
      op(1, 0, 1, 16'h7777, 0, 0, "R10 write after completion ignored");
      op(0, 1, 0, 16'h0, 0, 0, "R2 IP read hard init");
      // pass 2: enable clear
      op(1, 0, 1, 16'h3A45, 0, 0, "R3 R4 R7 no request when disabled");
      op(1, 0, 1, 16'h0000, 0, 0, "R5 R7 step three without request");
      op(1, 0, 0, 16'hFFFF, 0, 0, "R2 IP write hard init");
      // pass 3: enable set, zero vector
      op(1, 0, 1, 16'h0080, 0, 0, "R3 R7 zero vector blocks request");
      op(0, 1, 0, 16'h0, 0, 0, "R2 IP read from phase 2");
      op(1, 0, 1, 16'h7F81, 0, 0, "R3 R4 maximal ring lengths with request");
      op(1, 0, 0, 16'h0, 0, 0, "R2 IP write drops pending request");
      op(0, 0, 0, 16'h0, 0, 0, "R2 idle after hard init");
      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule